// File: doc/BRIEF.md
# Trap Entry State Update Unit

This block sits beside the trap logic of a processor with windowed registers and a three-level privilege model (user, privileged, hyperprivileged). When the trap logic raises a one-cycle request, the unit reads the current trap level, global level, window pointer, free-window count, processor state word and hypervisor state word. It decides where the trap goes and works out the next value of every one of those registers. The result is registered and appears on the outputs one clock after the request.

There are four routes: a recovery route, an error route, a hyperprivileged entry and a privileged entry. The route depends on the current privilege, the trap level and the trap type. The unit also returns a vector-select code and a vector index, which a later stage turns into the fetch address. Window spill, fill and save traps move the current window pointer. A spill trap moves it by an amount that depends on the free-window count.

Top module: `trap_entry_unit`

## Requirements
- R1: After reset every output is zero.
- R2: The current mode is hyperprivileged if hypervisor-state bit 2 is set; otherwise it is privileged if processor-state bit 2 is set; otherwise it is user. A hyperprivileged mode keeps the next level hyperprivileged. Any other mode targets the privileged level.
- R3: If hypervisor-state bit 5 is set, or TL equals MAX_TL-1, the recovery route is taken. On this route vec_kind is 1 and the index is 5. Hypervisor-state bits 5 and 2 are set. GL becomes min(GL+1, MAX_GL) and TL becomes min(TL+1, MAX_TL). Processor state and CWP are unchanged.
- R4: When R3 does not apply and TL is MAX_TL or more, error_o is 1 and vec_kind and the index are 0. TL, GL, CWP and both state words come out equal to their inputs, and the trap-type output keeps its previous value.
- R5: When R3 and R4 do not apply, TL is greater than MAX_PTL and the next level is privileged, a hyperprivileged entry with index 2 is taken.
- R6: Otherwise, if the next level is hyperprivileged or the trap type is 384 or more, a hyperprivileged entry (vec_kind 2) is taken, indexed by the trap type.
- R7: In every other case a privileged entry (vec_kind 3) is taken, indexed by the trap type. The vector level is the new TL.
- R8: On an entry under R5–R7, GL becomes GL+1. It saturates at MAX_PGL on a privileged entry and at MAX_GL on a hyperprivileged entry.
- R9: On an entry under R5–R7, processor-state bit 4 is set and bit 3 is cleared. A privileged entry also sets bit 2. All other bits are kept.
- R10: A hyperprivileged entry clears hypervisor-state bit 5 and sets bit 2. A privileged entry leaves the hypervisor state unchanged.
- R11: On an entry under R5–R7, CWP changes by +1 for type 0x24, by +(CANSAVE+2) for types 0x80–0xBF and by -1 for types 0xC0–0xFF. The result wraps modulo N_WIN. For all other types CWP is unchanged.
- R12: On every non-error route TL becomes TL+1 and the trap-type output takes the trap type. Outputs update on the edge that samples the request, and valid_o pulses for that one cycle. With no request, all outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trap_req_i | input | 1 | Trap request strobe |
| trap_type_i | input | TT_W | Trap type |
| tl_i | input | TL_W | Current trap level |
| gl_i | input | GL_W | Current global level |
| cwp_i | input | CWP_W | Current window pointer |
| cansave_i | input | CWP_W | Current free-window count |
| pstate_i | input | 10 | Current processor state word |
| hpstate_i | input | 12 | Current hypervisor state word |
| valid_o | output | 1 | Result updated this cycle |
| tl_o | output | TL_W | Next trap level |
| gl_o | output | GL_W | Next global level |
| cwp_o | output | CWP_W | Next window pointer |
| tt_o | output | TT_W | Recorded trap type |
| pstate_o | output | 10 | Next processor state word |
| hpstate_o | output | 12 | Next hypervisor state word |
| vec_kind_o | output | 2 | 0 none, 1 recovery, 2 hyperprivileged, 3 privileged |
| vec_idx_o | output | TT_W | Vector index |
| error_o | output | 1 | Error state requested |

## Verification
The window-range assertion assumes that cwp_i and cansave_i are both below N_WIN. The assertion is gated on that condition. The stimulus only drives window values inside that range, including the top value N_WIN-1 and the spill case where the sum lands exactly on 2*N_WIN. The bench is built with a window count that is not a power of two, so a wrap that simply drops high bits gives wrong results. The clocked assertions take for granted that the request is sampled on a clean edge. The bench drives it on the falling edge and holds it for exactly one cycle.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;
  localparam int PS_W = 10;
  localparam int HS_W = 12;
  localparam int PS_PRIV = 2;
  localparam int PS_AM = 3;
  localparam int PS_PEF = 4;
  localparam int HS_HPRIV = 2;
  localparam int HS_RED = 5;
  localparam int RED_IDX = 5;
  localparam int WDOG_IDX = 2;
  localparam int HYPER_TT_MIN = 384;
  localparam int TT_SAVE = 'h24;
  localparam int TT_SPILL_LO = 'h80;
  localparam int TT_SPILL_HI = 'hBF;
  localparam int TT_FILL_LO = 'hC0;
  localparam int TT_FILL_HI = 'hFF;

  typedef enum logic [1:0] {MODE_USER, MODE_PRIV, MODE_HYPER} mode_e;
  typedef enum logic [1:0] {VEC_NONE = 2'd0, VEC_RED = 2'd1, VEC_HYPER = 2'd2, VEC_PRIV = 2'd3} vec_kind_e;
  typedef enum logic [2:0] {RT_ERROR, RT_RED, RT_WDOG, RT_HYPER, RT_PRIV} route_e;
endpackage

// File: rtl/trap_route_sel.sv
module trap_route_sel
  import trap_entry_pkg::*;
#(
  parameter int MAX_TL  = 6,
  parameter int MAX_PTL = 2,
  parameter int TL_W    = 3,
  parameter int TT_W    = 9
) (
  input  logic [TL_W-1:0] tl_i,
  input  logic [TT_W-1:0] tt_i,
  input  logic [PS_W-1:0] pstate_i,
  input  logic [HS_W-1:0] hpstate_i,
  output mode_e           mode_o,
  output route_e          route_o
);
  localparam logic [TL_W:0] TL_RED  = (TL_W+1)'(MAX_TL - 1);
  localparam logic [TL_W:0] TL_ERR  = (TL_W+1)'(MAX_TL);
  localparam logic [TL_W:0] TL_PMAX = (TL_W+1)'(MAX_PTL);
  localparam logic [TT_W-1:0] TT_HMIN = TT_W'(HYPER_TT_MIN);

  logic [TL_W:0] tl_x;
  logic          next_hyper;

  assign tl_x = {1'b0, tl_i};

  always_comb begin
    if (hpstate_i[HS_HPRIV])     mode_o = MODE_HYPER;
    else if (pstate_i[PS_PRIV])  mode_o = MODE_PRIV;
    else                         mode_o = MODE_USER;
  end

  assign next_hyper = (mode_o == MODE_HYPER);

  // order encodes priority
  always_comb begin
    if (hpstate_i[HS_RED] || tl_x == TL_RED)     route_o = RT_RED;
    else if (tl_x >= TL_ERR)                      route_o = RT_ERROR;
    else if (tl_x > TL_PMAX && !next_hyper)       route_o = RT_WDOG;
    else if (next_hyper || tt_i >= TT_HMIN)       route_o = RT_HYPER;
    else                                          route_o = RT_PRIV;
  end

  always_comb begin
    if (hpstate_i[HS_RED]) begin
      assert_red_first_R3: assert (route_o == RT_RED);
    end
  end
endmodule

// File: rtl/trap_cwp_shift.sv
module trap_cwp_shift
  import trap_entry_pkg::*;
#(
  parameter int N_WIN = 8,
  parameter int CWP_W = 3,
  parameter int TT_W  = 9
) (
  input  logic [CWP_W-1:0] cwp_i,
  input  logic [CWP_W-1:0] cansave_i,
  input  logic [TT_W-1:0]  tt_i,
  output logic [CWP_W-1:0] cwp_o
);
  localparam int SUM_W = CWP_W + 2;
  localparam logic [SUM_W-1:0] NW1 = SUM_W'(N_WIN);
  localparam logic [SUM_W-1:0] NW2 = SUM_W'(2 * N_WIN);
  localparam logic [SUM_W-1:0] NWM1 = SUM_W'(N_WIN - 1);
  localparam logic [CWP_W:0] NW_CMP = (CWP_W+1)'(N_WIN);

  logic [SUM_W-1:0] cwp_x, cs_x, sum, red_sum;

  assign cwp_x = SUM_W'(cwp_i);
  assign cs_x  = SUM_W'(cansave_i);

  always_comb begin
    if (tt_i == TT_W'(TT_SAVE))
      sum = cwp_x + SUM_W'(1);
    else if (tt_i >= TT_W'(TT_SPILL_LO) && tt_i <= TT_W'(TT_SPILL_HI))
      sum = cwp_x + cs_x + SUM_W'(2);
    else if (tt_i >= TT_W'(TT_FILL_LO) && tt_i <= TT_W'(TT_FILL_HI))
      sum = cwp_x + NWM1;
    else
      sum = cwp_x;
  end

  // sum < 2*N_WIN+1 for in-range inputs, two compares replace a divider
  always_comb begin
    if (sum >= NW2)      red_sum = sum - NW2;
    else if (sum >= NW1) red_sum = sum - NW1;
    else                 red_sum = sum;
  end

  assign cwp_o = red_sum[CWP_W-1:0];

  always_comb begin
    if ({1'b0, cwp_i} < NW_CMP && {1'b0, cansave_i} < NW_CMP) begin
      assert_cwp_range_R11: assert ({1'b0, cwp_o} < NW_CMP);
    end
  end
endmodule

// File: rtl/trap_state_next.sv
module trap_state_next
  import trap_entry_pkg::*;
#(
  parameter int MAX_TL  = 6,
  parameter int MAX_GL  = 3,
  parameter int MAX_PGL = 2,
  parameter int TL_W    = 3,
  parameter int GL_W    = 2,
  parameter int TT_W    = 9
) (
  input  route_e          route_i,
  input  logic [TT_W-1:0] tt_i,
  input  logic [TL_W-1:0] tl_i,
  input  logic [GL_W-1:0] gl_i,
  input  logic [PS_W-1:0] pstate_i,
  input  logic [HS_W-1:0] hpstate_i,
  output logic [TL_W-1:0] tl_o,
  output logic [GL_W-1:0] gl_o,
  output logic [PS_W-1:0] pstate_o,
  output logic [HS_W-1:0] hpstate_o,
  output vec_kind_e       kind_o,
  output logic [TT_W-1:0] idx_o,
  output logic            err_o
);
  localparam logic [GL_W:0] GL_HCAP = (GL_W+1)'(MAX_GL);
  localparam logic [GL_W:0] GL_PCAP = (GL_W+1)'(MAX_PGL);
  localparam logic [TL_W:0] TL_CAP  = (TL_W+1)'(MAX_TL);

  logic [GL_W:0] gl_inc, gl_cap, gl_sat;
  logic [TL_W:0] tl_inc, tl_sat;

  assign gl_inc = {1'b0, gl_i} + (GL_W+1)'(1);
  assign gl_cap = (route_i == RT_PRIV) ? GL_PCAP : GL_HCAP;
  assign gl_sat = (gl_inc > gl_cap) ? gl_cap : gl_inc;
  assign tl_inc = {1'b0, tl_i} + (TL_W+1)'(1);
  assign tl_sat = (tl_inc > TL_CAP) ? TL_CAP : tl_inc;

  always_comb begin
    tl_o      = tl_sat[TL_W-1:0];
    gl_o      = gl_sat[GL_W-1:0];
    pstate_o  = pstate_i;
    hpstate_o = hpstate_i;
    kind_o    = VEC_NONE;
    idx_o     = '0;
    err_o     = 1'b0;
    unique case (route_i)
      RT_ERROR: begin
        tl_o  = tl_i;
        gl_o  = gl_i;
        err_o = 1'b1;
      end
      RT_RED: begin
        hpstate_o[HS_RED]   = 1'b1;
        hpstate_o[HS_HPRIV] = 1'b1;
        kind_o = VEC_RED;
        idx_o  = TT_W'(RED_IDX);
      end
      RT_WDOG, RT_HYPER: begin
        pstate_o[PS_PEF]    = 1'b1;
        pstate_o[PS_AM]     = 1'b0;
        hpstate_o[HS_RED]   = 1'b0;
        hpstate_o[HS_HPRIV] = 1'b1;
        kind_o = VEC_HYPER;
        idx_o  = (route_i == RT_WDOG) ? TT_W'(WDOG_IDX) : tt_i;
      end
      RT_PRIV: begin
        pstate_o[PS_PEF]  = 1'b1;
        pstate_o[PS_AM]   = 1'b0;
        pstate_o[PS_PRIV] = 1'b1;
        kind_o = VEC_PRIV;
        idx_o  = tt_i;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
  import trap_entry_pkg::*;
#(
  parameter int MAX_TL  = 6,
  parameter int MAX_PTL = 2,
  parameter int MAX_GL  = 3,
  parameter int MAX_PGL = 2,
  parameter int N_WIN   = 8,
  parameter int TT_W    = 9,
  localparam int TL_W   = $clog2(MAX_TL + 1),
  localparam int GL_W   = $clog2(MAX_GL + 1),
  localparam int CWP_W  = $clog2(N_WIN)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trap_req_i,
  input  logic [TT_W-1:0]  trap_type_i,
  input  logic [TL_W-1:0]  tl_i,
  input  logic [GL_W-1:0]  gl_i,
  input  logic [CWP_W-1:0] cwp_i,
  input  logic [CWP_W-1:0] cansave_i,
  input  logic [9:0]       pstate_i,
  input  logic [11:0]      hpstate_i,
  output logic             valid_o,
  output logic [TL_W-1:0]  tl_o,
  output logic [GL_W-1:0]  gl_o,
  output logic [CWP_W-1:0] cwp_o,
  output logic [TT_W-1:0]  tt_o,
  output logic [9:0]       pstate_o,
  output logic [11:0]      hpstate_o,
  output logic [1:0]       vec_kind_o,
  output logic [TT_W-1:0]  vec_idx_o,
  output logic             error_o
);
  mode_e            cur_mode;
  route_e           route;
  vec_kind_e        kind_d;
  logic [TL_W-1:0]  tl_d;
  logic [GL_W-1:0]  gl_d;
  logic [CWP_W-1:0] cwp_sh, cwp_d;
  logic [PS_W-1:0]  ps_d;
  logic [HS_W-1:0]  hs_d;
  logic [TT_W-1:0]  idx_d;
  logic             err_d;
  logic             moves_win;

  trap_route_sel #(.MAX_TL(MAX_TL), .MAX_PTL(MAX_PTL), .TL_W(TL_W), .TT_W(TT_W)) u_route (
    .tl_i(tl_i), .tt_i(trap_type_i), .pstate_i(pstate_i), .hpstate_i(hpstate_i),
    .mode_o(cur_mode), .route_o(route)
  );

  trap_cwp_shift #(.N_WIN(N_WIN), .CWP_W(CWP_W), .TT_W(TT_W)) u_cwp (
    .cwp_i(cwp_i), .cansave_i(cansave_i), .tt_i(trap_type_i), .cwp_o(cwp_sh)
  );

  trap_state_next #(
    .MAX_TL(MAX_TL), .MAX_GL(MAX_GL), .MAX_PGL(MAX_PGL),
    .TL_W(TL_W), .GL_W(GL_W), .TT_W(TT_W)
  ) u_next (
    .route_i(route), .tt_i(trap_type_i), .tl_i(tl_i), .gl_i(gl_i),
    .pstate_i(pstate_i), .hpstate_i(hpstate_i),
    .tl_o(tl_d), .gl_o(gl_d), .pstate_o(ps_d), .hpstate_o(hs_d),
    .kind_o(kind_d), .idx_o(idx_d), .err_o(err_d)
  );

  assign moves_win = (route == RT_WDOG) || (route == RT_HYPER) || (route == RT_PRIV);
  assign cwp_d     = moves_win ? cwp_sh : cwp_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o    <= 1'b0;
      tl_o       <= '0;
      gl_o       <= '0;
      cwp_o      <= '0;
      tt_o       <= '0;
      pstate_o   <= '0;
      hpstate_o  <= '0;
      vec_kind_o <= '0;
      vec_idx_o  <= '0;
      error_o    <= 1'b0;
    end else begin
      valid_o <= trap_req_i;
      if (trap_req_i) begin
        tl_o       <= tl_d;
        gl_o       <= gl_d;
        cwp_o      <= cwp_d;
        pstate_o   <= ps_d;
        hpstate_o  <= hs_d;
        vec_kind_o <= kind_d;
        vec_idx_o  <= idx_d;
        error_o    <= err_d;
        if (!err_d) tt_o <= trap_type_i;
      end
    end
  end

  assert_req_valid_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_req_i |=> valid_o);
  assert_idle_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trap_req_i |=> (!valid_o && $stable(tl_o) && $stable(cwp_o) && $stable(gl_o)));
  assert_err_novec_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |-> (vec_kind_o == VEC_NONE));
  assert_red_idx_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_kind_o == VEC_RED) |-> (vec_idx_o == TT_W'(RED_IDX) && hpstate_o[HS_RED]));
  assert_priv_bits_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && vec_kind_o == VEC_PRIV) |-> (pstate_o[PS_PEF] && !pstate_o[PS_AM] && pstate_o[PS_PRIV]));
  assert_hyper_bits_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && vec_kind_o == VEC_HYPER) |-> (hpstate_o[HS_HPRIV] && !hpstate_o[HS_RED]));
  assert_user_not_hyper_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_req_i && cur_mode == MODE_USER && trap_type_i < TT_W'(HYPER_TT_MIN)
     && !hpstate_i[HS_RED] && tl_i < TL_W'(MAX_PTL)) |=> (vec_kind_o == VEC_PRIV));
endmodule

// File: tb/trap_entry_unit_tb.sv
module trap_entry_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_TL = 6, MAX_PTL = 2, MAX_GL = 3, MAX_PGL = 2, N_WIN = 6, TT_W = 9;
  localparam int TL_W = 3, GL_W = 2, CWP_W = 3;

  logic clk = 1'b0, rst_ni = 1'b0, trap_req = 1'b0;
  logic [TT_W-1:0] tt_in = '0;
  logic [TL_W-1:0] tl_in = '0;
  logic [GL_W-1:0] gl_in = '0;
  logic [CWP_W-1:0] cwp_in = '0, cs_in = '0;
  logic [9:0] ps_in = '0;
  logic [11:0] hs_in = '0;
  logic valid, err;
  logic [TL_W-1:0] tl_out;
  logic [GL_W-1:0] gl_out;
  logic [CWP_W-1:0] cwp_out;
  logic [TT_W-1:0] tt_out, idx_out;
  logic [9:0] ps_out;
  logic [11:0] hs_out;
  logic [1:0] kind_out;

  int n_run = 0, n_fail = 0;
  int last_tt = 0;
  int e_tl, e_gl, e_cwp, e_ps, e_hs, e_kind, e_idx, e_err, e_tt;

  always #(CLK_PERIOD/2) clk = ~clk;

  trap_entry_unit #(.MAX_TL(MAX_TL), .MAX_PTL(MAX_PTL), .MAX_GL(MAX_GL),
                    .MAX_PGL(MAX_PGL), .N_WIN(N_WIN), .TT_W(TT_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .trap_req_i(trap_req), .trap_type_i(tt_in),
    .tl_i(tl_in), .gl_i(gl_in), .cwp_i(cwp_in), .cansave_i(cs_in),
    .pstate_i(ps_in), .hpstate_i(hs_in), .valid_o(valid), .tl_o(tl_out),
    .gl_o(gl_out), .cwp_o(cwp_out), .tt_o(tt_out), .pstate_o(ps_out),
    .hpstate_o(hs_out), .vec_kind_o(kind_out), .vec_idx_o(idx_out), .error_o(err)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // reference rules, computed from the requirement text
  task automatic model(input int tt, input int tl, input int gl, input int cwp,
                       input int cs, input int ps, input int hs);
    int mode, route, c;
    mode = hs[2] ? 2 : (ps[2] ? 1 : 0);
    if (hs[5] || tl == MAX_TL - 1) route = 1;
    else if (tl >= MAX_TL)          route = 0;
    else if (tl > MAX_PTL && mode != 2) route = 2;
    else if (mode == 2 || tt >= 384) route = 3;
    else route = 4;
    e_tl = tl; e_gl = gl; e_cwp = cwp; e_ps = ps; e_hs = hs;
    e_kind = 0; e_idx = 0; e_err = 0; e_tt = last_tt;
    if (route == 0) begin
      e_err = 1;
    end else begin
      e_tt = tt;
      e_tl = (tl + 1 > MAX_TL) ? MAX_TL : tl + 1;
      if (route == 1) begin
        e_hs = hs | 'h24; e_kind = 1; e_idx = 5;
        e_gl = (gl + 1 > MAX_GL) ? MAX_GL : gl + 1;
      end else begin
        c = cwp;
        if (tt == 'h24) c = cwp + 1;
        else if (tt >= 'h80 && tt <= 'hBF) c = cwp + cs + 2;
        else if (tt >= 'hC0 && tt <= 'hFF) c = cwp - 1 + N_WIN;
        e_cwp = c % N_WIN;
        e_ps = (ps | 'h10) & ~'h8;
        if (route == 4) begin
          e_ps = e_ps | 'h4; e_kind = 3; e_idx = tt;
          e_gl = (gl + 1 > MAX_PGL) ? MAX_PGL : gl + 1;
        end else begin
          e_hs = (hs & ~'h20) | 'h4; e_kind = 2; e_idx = (route == 2) ? 2 : tt;
          e_gl = (gl + 1 > MAX_GL) ? MAX_GL : gl + 1;
        end
      end
    end
  endtask

  task automatic run_trap(input string req, input int tt, input int tl, input int gl,
                          input int cwp, input int cs, input int ps, input int hs);
    @(negedge clk);
    tt_in = TT_W'(tt); tl_in = TL_W'(tl); gl_in = GL_W'(gl);
    cwp_in = CWP_W'(cwp); cs_in = CWP_W'(cs); ps_in = 10'(ps); hs_in = 12'(hs);
    trap_req = 1'b1;
    @(negedge clk);
    trap_req = 1'b0;
    model(tt, tl, gl, cwp, cs, ps, hs);
    last_tt = e_tt;
    chk("R12", "valid", int'(valid), 1);
    chk(req, "kind", int'(kind_out), e_kind);
    chk(req, "idx", int'(idx_out), e_idx);
    chk("R4", "error", int'(err), e_err);
    chk("R12", "tl", int'(tl_out), e_tl);
    chk("R12", "tt", int'(tt_out), e_tt);
    chk("R8", "gl", int'(gl_out), e_gl);
    chk("R11", "cwp", int'(cwp_out), e_cwp);
    chk("R9", "pstate", int'(ps_out), e_ps);
    chk("R10", "hpstate", int'(hs_out), e_hs);
  endtask

  task automatic test_reset;
    chk("R1", "valid", int'(valid), 0);
    chk("R1", "tl", int'(tl_out), 0);
    chk("R1", "cwp", int'(cwp_out), 0);
    chk("R1", "kind", int'(kind_out), 0);
    chk("R1", "error", int'(err), 0);
    chk("R1", "states", int'(ps_out) + int'(hs_out) + int'(gl_out) + int'(tt_out) + int'(idx_out), 0);
  endtask

  task automatic test_mode_R2;
    run_trap("R2", 'h10, 0, 0, 1, 0, 'h000, 'h004);
    run_trap("R2", 'h10, 0, 0, 1, 0, 'h004, 'h000);
    run_trap("R2", 'h10, 1, 0, 1, 0, 'h000, 'h000);
    run_trap("R2", 'h10, 3, 0, 1, 0, 'h004, 'h804);
  endtask

  task automatic test_red_R3;
    run_trap("R3", 'h30, 1, 1, 2, 1, 'h3CB, 'h020);
    run_trap("R3", 'h30, MAX_TL - 1, 3, 2, 1, 'h004, 'h000);
    run_trap("R3", 'h30, MAX_TL, 2, 4, 1, 'h000, 'h024);
  endtask

  task automatic test_error_R4;
    run_trap("R3", 'h41, 0, 0, 0, 0, 'h000, 'h000);
    run_trap("R4", 'h55, MAX_TL, 1, 3, 2, 'h20A, 'h400);
    run_trap("R4", 'h55, 7, 2, 5, 0, 'h004, 'h004);
  endtask

  task automatic test_wdog_R5;
    run_trap("R5", 'h41, MAX_PTL + 1, 0, 2, 0, 'h000, 'h000);
    run_trap("R5", 'h41, MAX_PTL + 1, 1, 2, 0, 'h004, 'h000);
    run_trap("R7", 'h41, MAX_PTL, 1, 2, 0, 'h004, 'h000);
  endtask

  task automatic test_hyper_R6;
    run_trap("R7", 383, 1, 0, 3, 0, 'h004, 'h000);
    run_trap("R6", 384, 1, 0, 3, 0, 'h004, 'h000);
    run_trap("R6", 'h12, 0, 1, 3, 0, 'h000, 'h804);
  endtask

  task automatic test_gl_R8;
    run_trap("R8", 'h10, 0, 1, 0, 0, 'h000, 'h000);
    run_trap("R8", 'h10, 0, 2, 0, 0, 'h000, 'h000);
    run_trap("R8", 'h10, 0, 3, 0, 0, 'h004, 'h000);
    run_trap("R8", 'h10, 0, 2, 0, 0, 'h000, 'h004);
    run_trap("R8", 'h10, 0, 3, 0, 0, 'h000, 'h004);
  endtask

  task automatic test_state_R9_R10;
    run_trap("R9", 'h10, 0, 0, 0, 0, 'h3CB, 'hC01);
    run_trap("R10", 400, 0, 0, 0, 0, 'h3CB, 'hC01);
  endtask

  task automatic test_cwp_R11;
    run_trap("R11", 'h23, 0, 0, 5, 0, 0, 0);
    run_trap("R11", 'h24, 0, 0, 5, 0, 0, 0);
    run_trap("R11", 'h7F, 0, 0, 5, 3, 0, 0);
    run_trap("R11", 'h80, 0, 0, 5, 5, 0, 0);
    run_trap("R11", 'h80, 0, 0, 4, 5, 0, 0);
    run_trap("R11", 'hBF, 0, 0, 1, 0, 0, 0);
    run_trap("R11", 'hC0, 0, 0, 0, 2, 0, 0);
    run_trap("R11", 'hFF, 0, 0, 3, 2, 0, 0);
    run_trap("R11", 'h100, 0, 0, 3, 2, 0, 0);
    run_trap("R11", 'h24, MAX_PTL + 1, 0, 5, 0, 0, 0);
  endtask

  task automatic test_hold_R12;
    run_trap("R12", 'h24, 1, 1, 2, 0, 'h004, 'h000);
    tt_in = '1; tl_in = '0; cwp_in = 3'd1; hs_in = 12'h020;
    repeat (2) @(negedge clk);
    chk("R12", "valid idle", int'(valid), 0);
    chk("R12", "tl hold", int'(tl_out), e_tl);
    chk("R12", "cwp hold", int'(cwp_out), e_cwp);
    chk("R12", "tt hold", int'(tt_out), e_tt);
    chk("R12", "hpstate hold", int'(hs_out), e_hs);
  endtask

  initial begin : wdog
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog R12: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    test_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    test_mode_R2();
    test_red_R3();
    test_error_R4();
    test_wdog_R5();
    test_hyper_R6();
    test_gl_R8();
    test_state_R9_R10();
    test_cwp_R11();
    test_hold_R12();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule